// File: doc/BRIEF.md
# Byte-Lane NOR Flash Command Sequencer

This block turns one host request into the bus-cycle sequence that a group of byte-wide NOR flash dies needs. It handles three operations: program a word, erase one sector, or erase the whole chip. The dies sit side by side on a 32-bit data bus. Each die owns one byte lane and has its own write strobe. All dies share the address, the chip select and the output enable. A lane mask picks which dies take part. Every command byte is copied onto all lanes, and only the selected lanes see their write strobe pulse.

When the last command write has gone out, the block releases the data bus and reads the target location over and over. The embedded operation is finished once the top bit of every selected lane shows its final value. For a program that is the bit that was written. For an erase it is 1. If that never happens within a timeout budget set separately for each operation type, the request ends with an error flag. The host sees a busy level while the request runs and a one-cycle done pulse at the end. The error flag is updated with that pulse and holds its value until the next completion.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, and whenever busy is low, the chip select, output enable and all write strobes are high (inactive), the data bus is not driven, busy is 0 and done is 0.
- R2: A program request (op code 2'b00) produces exactly four writes on each selected lane, in this order: AAh at address 5555h, 55h at 2AAAh, A0h at 5555h, and then that lane's byte of the request data (lane i carries data bits 8i+7..8i) at the request address.
- R3: A sector-erase request (op code 2'b01) produces six writes on each selected lane: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, and then 30h at an address that keeps bits 18..16 of the request address and has bits 15..0 at zero.
- R4: A chip-erase request (op code 2'b10) produces the same first five writes as R3 and then writes 10h at 5555h.
- R5: Only lanes whose mask bit is 1 receive write strobe pulses. Bit i of the mask selects lane i.
- R6: Each write strobe stays low for exactly WE_LOW_CYC clock cycles. Address and data stay stable for as long as any strobe is low.
- R7: After the last write, the block reads the request address with output enable low, all strobes high and the bus released. It finishes without error on the first read in which every selected lane's bit 7 equals the expected value: the written data bit 7 for a program, 1 for an erase. Lanes outside the mask are ignored.
- R8: If no read matches, the request ends with the error flag set after exactly PROG_TMO, SECT_TMO or CHIP_TMO reads, depending on the op code. The error flag changes only in a cycle where done is high, and a successful completion clears it.
- R9: A request with op code 2'b11 or with an all-zero mask is rejected: done and the error flag are 1 in the cycle after it is presented, busy stays low, and no strobe moves.
- R10: A request presented while busy is high is ignored. The running sequence completes unchanged and no further operation starts after it.
- R11: Busy is high from the cycle after a valid request is accepted until completion. Done is a single pulse in the first cycle that busy is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, sampled when idle |
| reqOp | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 invalid |
| reqAddr | input | ADDR_W | Target byte address on every die |
| reqData | input | 8*LANES | Program data, one byte per lane |
| reqMask | input | LANES | Lane select |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Last completion failed (timeout or rejected) |
| fAddr | output | ADDR_W | Flash address bus |
| fDataOut | output | 8*LANES | Flash write data |
| fDataOe | output | 1 | Drive enable for fDataOut |
| fPollBit | input | LANES | Bit 7 of each lane read back from the flash |
| fCeN | output | 1 | Shared chip select, active low |
| fOeN | output | 1 | Shared output enable, active low |
| fWeN | output | LANES | Per-lane write strobes, active low |

## Verification
The bench runs a program with a sparse mask and mixed data bit 7 values. This shows that each lane polls against its own expected bit rather than a shared constant, and that masked-off lanes get no strobes. Sector and chip erases are run with different masks and addresses, so the sector-address truncation can be told apart from the fixed unlock address on the final write. A lane outside the mask that reports "busy" forever shows that unselected lanes are left out of completion. Timeouts are run on two op codes, so the read count proves that each op uses its own limit. Invalid op codes, an empty mask, and a request issued mid-sequence cover the paths that must not disturb the bus.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_BAD  = 2'b11
  } cmdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture request fields, restart step count
    logic nextStep;  // advance to the next command write
    logic clrTmo;    // clear poll attempt counter
    logic incTmo;    // one more failed poll
    logic pollSel;   // level: address bus shows the target for polling
  } dpStrobe_t;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_FIRST     = 8'hAA;
  localparam logic [7:0]  KEY_SECOND    = 8'h55;
  localparam logic [7:0]  CMD_PROGRAM   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE_ARM = 8'h80;
  localparam logic [7:0]  CMD_ERASE_ALL = 8'h10;
  localparam logic [7:0]  CMD_ERASE_SEC = 8'h30;

endpackage

// File: rtl/nor_cmd_dpath.sv
module nor_cmd_dpath
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int LANES     = 4,
  parameter int SECT_BITS = 3,
  parameter int PROG_TMO  = 2048,
  parameter int SECT_TMO  = 300000000,
  parameter int CHIP_TMO  = 1200000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [8*LANES-1:0]  reqData,
  input  logic [LANES-1:0]    reqMask,
  input  logic [LANES-1:0]    pollBit,
  output logic                reqBad,
  output logic                lastStep,
  output logic                pollMatch,
  output logic                tmoHit,
  output logic [ADDR_W-1:0]   cmdAddr,
  output logic [8*LANES-1:0]  cmdData,
  output logic [LANES-1:0]    laneMask
);

  localparam int DATA_W  = 8 * LANES;
  localparam int TMO_MAX = (PROG_TMO > SECT_TMO) ?
                           ((PROG_TMO > CHIP_TMO) ? PROG_TMO : CHIP_TMO) :
                           ((SECT_TMO > CHIP_TMO) ? SECT_TMO : CHIP_TMO);
  localparam int TMO_W   = $clog2(TMO_MAX + 1);
  localparam int LOW_W   = ADDR_W - SECT_BITS;

  typedef enum logic [1:0] {AS_UNLOCK_A, AS_UNLOCK_B, AS_TARGET, AS_SECTOR} addrSel_e;

  cmdOp_e              opQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [DATA_W-1:0]   dataQ;
  logic [LANES-1:0]    maskQ;
  logic [2:0]          stepQ;
  logic [TMO_W-1:0]    tmoQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_PROG;
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
      stepQ <= '0;
      tmoQ  <= '0;
    end else begin
      if (stb.loadReq) begin
        opQ   <= cmdOp_e'(reqOp);
        addrQ <= reqAddr;
        dataQ <= reqData;
        maskQ <= reqMask;
        stepQ <= '0;
      end else if (stb.nextStep) begin
        stepQ <= stepQ + 3'd1;
      end
      if (stb.clrTmo)      tmoQ <= '0;
      else if (stb.incTmo) tmoQ <= tmoQ + 1'b1;
    end
  end

  logic isProg;
  assign isProg   = (opQ == OP_PROG);
  assign reqBad   = (reqOp == OP_BAD) || (reqMask == '0);
  assign lastStep = isProg ? (stepQ == 3'd3) : (stepQ == 3'd5);
  assign laneMask = maskQ;

  // command table: which byte and which address for the current step
  logic [7:0] cmdByte;
  logic       useData;
  addrSel_e   addrSel;

  always_comb begin
    cmdByte = KEY_FIRST;
    useData = 1'b0;
    addrSel = AS_UNLOCK_A;
    if (isProg) begin
      unique case (stepQ)
        3'd0:    begin cmdByte = KEY_FIRST;   addrSel = AS_UNLOCK_A; end
        3'd1:    begin cmdByte = KEY_SECOND;  addrSel = AS_UNLOCK_B; end
        3'd2:    begin cmdByte = CMD_PROGRAM; addrSel = AS_UNLOCK_A; end
        default: begin useData = 1'b1;        addrSel = AS_TARGET;   end
      endcase
    end else begin
      unique case (stepQ)
        3'd0:    begin cmdByte = KEY_FIRST;     addrSel = AS_UNLOCK_A; end
        3'd1:    begin cmdByte = KEY_SECOND;    addrSel = AS_UNLOCK_B; end
        3'd2:    begin cmdByte = CMD_ERASE_ARM; addrSel = AS_UNLOCK_A; end
        3'd3:    begin cmdByte = KEY_FIRST;     addrSel = AS_UNLOCK_A; end
        3'd4:    begin cmdByte = KEY_SECOND;    addrSel = AS_UNLOCK_B; end
        default: begin
          if (opQ == OP_CHIP) begin
            cmdByte = CMD_ERASE_ALL;
            addrSel = AS_UNLOCK_A;
          end else begin
            cmdByte = CMD_ERASE_SEC;
            addrSel = AS_SECTOR;
          end
        end
      endcase
    end
    if (stb.pollSel) addrSel = AS_TARGET;
  end

  always_comb begin
    unique case (addrSel)
      AS_UNLOCK_A: cmdAddr = ADDR_W'(UNLOCK_ADDR_A);
      AS_UNLOCK_B: cmdAddr = ADDR_W'(UNLOCK_ADDR_B);
      AS_SECTOR:   cmdAddr = {addrQ[ADDR_W-1 -: SECT_BITS], {LOW_W{1'b0}}};
      default:     cmdAddr = addrQ;
    endcase
  end

  // per-lane replication of the command byte and completion compare
  logic [LANES-1:0] laneDone;
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic expBit;
    assign cmdData[8*g +: 8] = useData ? dataQ[8*g +: 8] : cmdByte;
    assign expBit            = isProg ? dataQ[8*g + 7] : 1'b1;
    assign laneDone[g]       = !maskQ[g] || (pollBit[g] == expBit);
  end
  assign pollMatch = &laneDone;

  // per-operation poll budget
  logic [TMO_W-1:0] tmoLast;
  always_comb begin
    unique case (opQ)
      OP_PROG: tmoLast = TMO_W'(PROG_TMO - 1);
      OP_SECT: tmoLast = TMO_W'(SECT_TMO - 1);
      default: tmoLast = TMO_W'(CHIP_TMO - 1);
    endcase
  end
  assign tmoHit = (tmoQ == tmoLast);

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int WE_LOW_CYC  = 5,
  parameter int WE_HIGH_CYC = 3,
  parameter int POLL_CYC    = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqBad,
  input  logic       lastStep,
  input  logic       pollMatch,
  input  logic       tmoHit,
  output dpStrobe_t  stb,
  output logic       busOe,
  output logic       ceN,
  output logic       oeN,
  output logic       weLow,
  output logic       busy,
  output logic       done,
  output logic       errFlag
);

  localparam int PH_MAX = (WE_LOW_CYC > WE_HIGH_CYC) ?
                          ((WE_LOW_CYC > POLL_CYC) ? WE_LOW_CYC : POLL_CYC) :
                          ((WE_HIGH_CYC > POLL_CYC) ? WE_HIGH_CYC : POLL_CYC);
  localparam int PH_W   = $clog2(PH_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_WLOW, S_WHIGH, S_PREAD, S_PGAP} state_e;

  state_e          stateQ, stateD;
  logic [PH_W-1:0] phQ, phD;
  logic            doneQ, doneD, errQ, errD;

  logic lowEnd, highEnd, readEnd;
  assign lowEnd  = (phQ == PH_W'(WE_LOW_CYC - 1));
  assign highEnd = (phQ == PH_W'(WE_HIGH_CYC - 1));
  assign readEnd = (phQ == PH_W'(POLL_CYC - 1));

  always_comb begin
    stateD       = stateQ;
    phD          = phQ;
    doneD        = 1'b0;
    errD         = errQ;
    stb          = '0;
    stb.pollSel  = (stateQ == S_PREAD) || (stateQ == S_PGAP);
    unique case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          if (reqBad) begin
            doneD = 1'b1;
            errD  = 1'b1;
          end else begin
            stb.loadReq = 1'b1;
            stb.clrTmo  = 1'b1;
            stateD      = S_SETUP;
          end
        end
      end
      S_SETUP: begin
        stateD = S_WLOW;
        phD    = '0;
      end
      S_WLOW: begin
        if (lowEnd) begin
          stateD = S_WHIGH;
          phD    = '0;
        end else begin
          phD = phQ + 1'b1;
        end
      end
      S_WHIGH: begin
        if (highEnd) begin
          phD = '0;
          if (lastStep) begin
            stateD = S_PREAD;
          end else begin
            stb.nextStep = 1'b1;
            stateD       = S_SETUP;
          end
        end else begin
          phD = phQ + 1'b1;
        end
      end
      S_PREAD: begin
        if (readEnd) begin
          phD = '0;
          if (pollMatch) begin
            doneD  = 1'b1;
            errD   = 1'b0;
            stateD = S_IDLE;
          end else if (tmoHit) begin
            doneD  = 1'b1;
            errD   = 1'b1;
            stateD = S_IDLE;
          end else begin
            stb.incTmo = 1'b1;
            stateD     = S_PGAP;
          end
        end else begin
          phD = phQ + 1'b1;
        end
      end
      S_PGAP: begin
        stateD = S_PREAD;
        phD    = '0;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      phQ    <= '0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      phQ    <= phD;
      doneQ  <= doneD;
      errQ   <= errD;
    end
  end

  assign busOe   = (stateQ == S_SETUP) || (stateQ == S_WLOW) || (stateQ == S_WHIGH);
  assign weLow   = (stateQ == S_WLOW);
  assign oeN     = (stateQ != S_PREAD);
  assign ceN     = (stateQ == S_IDLE);
  assign busy    = (stateQ != S_IDLE);
  assign done    = doneQ;
  assign errFlag = errQ;

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int LANES       = 4,
  parameter int SECT_BITS   = 3,
  parameter int WE_LOW_CYC  = 5,
  parameter int WE_HIGH_CYC = 3,
  parameter int POLL_CYC    = 12,
  parameter int PROG_TMO    = 2048,
  parameter int SECT_TMO    = 300000000,
  parameter int CHIP_TMO    = 1200000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [8*LANES-1:0]  reqData,
  input  logic [LANES-1:0]    reqMask,
  output logic                busy,
  output logic                done,
  output logic                errFlag,
  output logic [ADDR_W-1:0]   fAddr,
  output logic [8*LANES-1:0]  fDataOut,
  output logic                fDataOe,
  input  logic [LANES-1:0]    fPollBit,
  output logic                fCeN,
  output logic                fOeN,
  output logic [LANES-1:0]    fWeN
);

  dpStrobe_t        stb;
  logic             reqBad, lastStep, pollMatch, tmoHit, weLow;
  logic [LANES-1:0] laneMask;

  nor_cmd_ctrl #(
    .WE_LOW_CYC (WE_LOW_CYC),
    .WE_HIGH_CYC(WE_HIGH_CYC),
    .POLL_CYC   (POLL_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqBad   (reqBad),
    .lastStep (lastStep),
    .pollMatch(pollMatch),
    .tmoHit   (tmoHit),
    .stb      (stb),
    .busOe    (fDataOe),
    .ceN      (fCeN),
    .oeN      (fOeN),
    .weLow    (weLow),
    .busy     (busy),
    .done     (done),
    .errFlag  (errFlag)
  );

  nor_cmd_dpath #(
    .ADDR_W   (ADDR_W),
    .LANES    (LANES),
    .SECT_BITS(SECT_BITS),
    .PROG_TMO (PROG_TMO),
    .SECT_TMO (SECT_TMO),
    .CHIP_TMO (CHIP_TMO)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .reqMask  (reqMask),
    .pollBit  (fPollBit),
    .reqBad   (reqBad),
    .lastStep (lastStep),
    .pollMatch(pollMatch),
    .tmoHit   (tmoHit),
    .cmdAddr  (fAddr),
    .cmdData  (fDataOut),
    .laneMask (laneMask)
  );

  assign fWeN = ~({LANES{weLow}} & laneMask);

endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk #(
  parameter int ADDR_W = 19,
  parameter int LANES  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               done,
  input logic               errFlag,
  input logic [ADDR_W-1:0]  fAddr,
  input logic [8*LANES-1:0] fDataOut,
  input logic               fDataOe,
  input logic               fCeN,
  input logic               fOeN,
  input logic [LANES-1:0]   fWeN,
  input logic [LANES-1:0]   laneMask
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (fCeN && fOeN && (&fWeN) && !fDataOe));

  assert_we_in_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((~fWeN) & (~laneMask)) == '0);

  assert_bus_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!(&fWeN) && !(&$past(fWeN))) |-> ($stable(fAddr) && $stable(fDataOut)));

  assert_read_released_R7: assert property (@(posedge clk) disable iff (!rstN)
    !fOeN |-> (!fDataOe && (&fWeN) && !fCeN));

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(errFlag));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind nor_cmd_seq nor_cmd_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .errFlag (errFlag),
  .fAddr   (fAddr),
  .fDataOut(fDataOut),
  .fDataOe (fDataOe),
  .fCeN    (fCeN),
  .fOeN    (fOeN),
  .fWeN    (fWeN),
  .laneMask(laneMask)
);

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;

  localparam int ADDR_W = 19;
  localparam int LANES  = 4;
  localparam int WE_LOW = 5;
  localparam int WE_HI  = 3;
  localparam int POLLC  = 2;
  localparam int P_TMO  = 6;
  localparam int S_TMO  = 10;
  localparam int C_TMO  = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [1:0]        reqOp = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       reqData = '0;
  logic [LANES-1:0]  reqMask = '0;
  logic              busy, done, errFlag, fDataOe, fCeN, fOeN;
  logic [ADDR_W-1:0] fAddr;
  logic [31:0]       fDataOut;
  logic [LANES-1:0]  fPollBit, fWeN;

  always #4 clk = ~clk;

  nor_cmd_seq #(
    .ADDR_W(ADDR_W), .LANES(LANES), .SECT_BITS(3),
    .WE_LOW_CYC(WE_LOW), .WE_HIGH_CYC(WE_HI), .POLL_CYC(POLLC),
    .PROG_TMO(P_TMO), .SECT_TMO(S_TMO), .CHIP_TMO(C_TMO)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqMask(reqMask),
    .busy(busy), .done(done), .errFlag(errFlag), .fAddr(fAddr),
    .fDataOut(fDataOut), .fDataOe(fDataOe), .fPollBit(fPollBit),
    .fCeN(fCeN), .fOeN(fOeN), .fWeN(fWeN)
  );

  // ---------------- flash model (single writer process) ----------------
  logic [ADDR_W-1:0] wrA [LANES][8];
  logic [7:0]        wrD [LANES][8];
  int                wrN [LANES];
  int                lowCnt [LANES];
  int                badWidth;
  int                pollsSeen;
  logic [LANES-1:0]  weP;
  logic              oeP, busyP;
  int                budget [LANES];
  logic [7:0]        trueB [LANES];

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) begin wrN[i] = 0; lowCnt[i] = 0; end
      badWidth = 0; pollsSeen = 0; weP = '1; oeP = 1'b1; busyP = 1'b0;
    end else begin
      if (busy && !busyP) begin
        for (int i = 0; i < LANES; i++) begin wrN[i] = 0; lowCnt[i] = 0; end
        badWidth = 0; pollsSeen = 0;
      end
      for (int i = 0; i < LANES; i++) begin
        if (!fWeN[i]) lowCnt[i]++;
        if (fWeN[i] && !weP[i]) begin
          if (lowCnt[i] != WE_LOW) badWidth++;
          if (wrN[i] < 8) begin
            wrA[i][wrN[i]] = fAddr;
            wrD[i][wrN[i]] = fDataOut[8*i +: 8];
          end
          wrN[i]++;
          lowCnt[i] = 0;
        end
      end
      if (fOeN && !oeP) pollsSeen++;
      weP = fWeN; oeP = fOeN; busyP = busy;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++)
      fPollBit[i] = (pollsSeen < budget[i]) ? ~trueB[i][7] : trueB[i][7];
  end

  // ---------------- checking helpers ----------------
  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] expWr(input int op, input int idx, input logic [ADDR_W-1:0] a, input logic [7:0] db);
    if (op == 0) begin
      case (idx)
        0: return {19'h05555, 8'hAA};
        1: return {19'h02AAA, 8'h55};
        2: return {19'h05555, 8'hA0};
        default: return {a, db};
      endcase
    end
    case (idx)
      0: return {19'h05555, 8'hAA};
      1: return {19'h02AAA, 8'h55};
      2: return {19'h05555, 8'h80};
      3: return {19'h05555, 8'hAA};
      4: return {19'h02AAA, 8'h55};
      default: return (op == 2) ? {19'h05555, 8'h10} : {a[18:16], 16'h0000, 8'h30};
    endcase
  endfunction

  task automatic checkWrites(input int op, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             input logic [3:0] m, input string tag);
    for (int i = 0; i < LANES; i++) begin
      int n;
      n = m[i] ? ((op == 0) ? 4 : 6) : 0;
      chk(wrN[i] == n, $sformatf("%s R5 lane%0d write count", tag, i), wrN[i], n);
      for (int k = 0; k < n && k < 8; k++) begin
        logic [26:0] e;
        e = expWr(op, k, a, d[8*i +: 8]);
        chk({wrA[i][k], wrD[i][k]} == e, $sformatf("%s lane%0d write%0d", tag, i, k),
            {wrA[i][k], wrD[i][k]}, e);
      end
    end
    chk(badWidth == 0, {tag, " R6 strobe width"}, badWidth, 0);
  endtask

  task automatic startReq(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    reqOp = op; reqAddr = a; reqData = d; reqMask = m; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(input string tag, output logic errSeen);
    int cyc;
    cyc = 0;
    errSeen = 1'b0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, {tag, " R11 done seen"}, done, 1);
    chk(!busy, {tag, " R11 busy low with done"}, busy, 0);
    errSeen = errFlag;
    @(negedge clk);
    chk(!done, {tag, " R11 done single pulse"}, done, 0);
    @(negedge clk);
  endtask

  task automatic setModel(input logic [31:0] tb, input int b0, input int b1, input int b2, input int b3);
    for (int i = 0; i < LANES; i++) trueB[i] = tb[8*i +: 8];
    budget[0] = b0; budget[1] = b1; budget[2] = b2; budget[3] = b3;
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    @(negedge clk);
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    chk(fCeN && fOeN && fWeN == 4'hF && !fDataOe, "R1 reset bus idle",
        {fCeN, fOeN, fWeN, fDataOe}, 7'b1111110);
  endtask

  task automatic testProgram();
    logic e;
    setModel(32'hC35A817E, 3, 3, 3, 3);
    startReq(2'b00, 19'h41234, 32'hC35A817E, 4'b1011);
    chk(busy, "R11 busy after accept", busy, 1);
    waitDone("R2 program", e);
    chk(!e, "R7 program ok", e, 0);
    chk(pollsSeen == 4, "R7 program poll count", pollsSeen, 4);
    checkWrites(0, 19'h41234, 32'hC35A817E, 4'b1011, "R2 program");
  endtask

  task automatic testSector();
    logic e;
    setModel(32'hFFFFFFFF, 2, 2, 2, 2);
    startReq(2'b01, 19'h5ABCD, 32'h0, 4'b1111);
    waitDone("R3 sector", e);
    chk(!e, "R7 sector ok", e, 0);
    chk(pollsSeen == 3, "R7 sector poll count", pollsSeen, 3);
    checkWrites(1, 19'h5ABCD, 32'h0, 4'b1111, "R3 sector");
  endtask

  task automatic testChip();
    logic e;
    setModel(32'hFFFFFFFF, 0, 1, 1, 0);
    startReq(2'b10, 19'h3F00F, 32'h0, 4'b0110);
    waitDone("R4 chip", e);
    chk(!e, "R7 chip ok", e, 0);
    chk(pollsSeen == 2, "R7 chip poll count", pollsSeen, 2);
    checkWrites(2, 19'h3F00F, 32'h0, 4'b0110, "R4 chip");
  endtask

  task automatic testIgnoredLane();
    logic e;
    setModel(32'h00000080, 1, 100000, 100000, 100000);
    startReq(2'b00, 19'h00010, 32'h00000080, 4'b0001);
    waitDone("R7 masked lanes", e);
    chk(!e, "R7 unselected busy lanes ignored", e, 0);
    chk(pollsSeen == 2, "R7 masked poll count", pollsSeen, 2);
  endtask

  task automatic testTimeout();
    logic e;
    setModel(32'h00004200, 0, 100000, 0, 0);
    startReq(2'b00, 19'h00100, 32'h00004200, 4'b0010);
    waitDone("R8 program timeout", e);
    chk(e, "R8 program timeout error", e, 1);
    chk(pollsSeen == P_TMO, "R8 program timeout polls", pollsSeen, P_TMO);
    repeat (4) @(negedge clk);
    chk(errFlag, "R8 error held while idle", errFlag, 1);
    setModel(32'hFFFFFFFF, 0, 0, 100000, 0);
    startReq(2'b01, 19'h20000, 32'h0, 4'b0100);
    waitDone("R8 sector timeout", e);
    chk(e, "R8 sector timeout error", e, 1);
    chk(pollsSeen == S_TMO, "R8 sector timeout polls", pollsSeen, S_TMO);
  endtask

  task automatic testBadReq();
    startReq(2'b11, 19'h00000, 32'h0, 4'b1111);
    chk(done && errFlag && !busy, "R9 bad op rejected", {done, errFlag, busy}, 3'b110);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(fCeN && fWeN == 4'hF && !busy, "R9 bad op no bus activity", {fCeN, fWeN, busy}, 6'b111110);
    end
    startReq(2'b00, 19'h00000, 32'h0, 4'b0000);
    chk(done && errFlag && !busy, "R9 empty mask rejected", {done, errFlag, busy}, 3'b110);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(fCeN && fWeN == 4'hF && !busy, "R9 empty mask no bus activity", {fCeN, fWeN, busy}, 6'b111110);
    end
  endtask

  task automatic testBusyIgnore();
    logic e;
    setModel(32'h11223344, 1, 1, 1, 1);
    startReq(2'b00, 19'h7FFFF, 32'h11223344, 4'b1100);
    repeat (15) @(negedge clk);
    reqOp = 2'b10; reqMask = 4'b1111; reqAddr = 19'h0; reqData = 32'h0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone("R10 busy ignore", e);
    chk(!e, "R8 error cleared by success", e, 0);
    checkWrites(0, 19'h7FFFF, 32'h11223344, 4'b1100, "R10 busy ignore");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!busy && fWeN == 4'hF, "R10 no second operation", {busy, fWeN}, 5'b01111);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    setModel(32'hFFFFFFFF, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testProgram();
    testSector();
    testChip();
    testIgnoredLane();
    testTimeout();
    testBadReq();
    testBusyIgnore();
    finishRun();
  end

  initial begin
    #(8 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule